// File: doc/BRIEF.md
# Dual-Bank Layer Result Buffer

This block holds the activations that move between consecutive layers of a fully connected network engine. Layers are evaluated one at a time. While a layer is being computed, its accumulator stage writes finished results into an input bank, N values per cycle. At the same time, the output bank holds the results of the previous layer, which form the input vector of the current layer. The output bank serves these to the requantizer and dot-product tile, M values per cycle.

Both banks are built from flip-flops, so every cycle can take a full write group and give a full read group. When all neuron outputs of a layer are complete, the controller pulses a transfer strobe while the global maximum is being resolved. In that one cycle the whole input bank is copied into the output bank, so the next layer starts with no stall. For the first layer, a source select routes an external input vector onto the read port in place of the output bank. A length input zeroes read lanes that lie past the end of the current vector.

Top module: `lrb_top`

## Requirements
- R1: After a synchronous active-low reset, both banks hold zero, and every in-range read from the output bank returns 0.
- R2: A write with `wr_en` high and `wr_idx` = g places lane k of `wr_data` (bits k*32 +: 32) into input entry g*N+k. All other entries keep their values.
- R3: A write whose `wr_idx` is DEPTH/N or higher changes no entry.
- R4: Writes into the input bank do not appear on `rd_data` until a transfer has taken place.
- R5: A cycle with `xfer` high copies every entry of the input bank into the output bank. The copied values can be read in the cycle after that edge.
- R6: The output bank keeps its contents in every cycle in which `xfer` is low. The input bank is not cleared by a transfer.
- R7: A write in the same cycle as a transfer is left out of the copied image. It lands in the input bank and reaches the output bank at the following transfer.
- R8: The read port is combinational. Lane k of `rd_data` (bits k*32 +: 32) returns element `rd_idx`*M+k.
- R9: Lane k returns 0 whenever `rd_idx`*M+k is greater than or equal to `rd_len`. This includes every lane of a group index beyond the depth.
- R10: With `ext_sel` high, lane k returns lane k of `ext_data` instead of the output bank. The same length masking applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the input bank |
| wr_idx | input | 3 | Aligned write group index (group of N entries) |
| wr_data | input | N*32 | N accumulator results, lane 0 in the low bits |
| xfer | input | 1 | Copy the whole input bank into the output bank |
| ext_sel | input | 1 | Read from `ext_data` instead of the output bank |
| ext_data | input | M*32 | External input vector slice for the first layer |
| rd_idx | input | 2 | Aligned read group index (group of M entries) |
| rd_len | input | 4 | Number of valid elements in the vector being read |
| rd_data | output | M*32 | M elements of the selected group |

## Verification
The checks assume that `rst_n` is held low for at least one clock edge before the first operation. They also assume that `rd_len` never exceeds DEPTH. The bench drives every input on the falling edge, keeps `rd_len` within 0 to 12, and deliberately aims write indices 6 and 7 past the six valid write groups. The transfer-copy and hold properties take nothing more from the inputs than a defined `xfer` level. The stimulus never leaves `xfer` or `wr_en` undriven after reset.

// File: rtl/lrb_pkg.sv
`timescale 1ns/1ps
// Package: lrb_pkg
// Shared helpers for the dual-bank layer result buffer.
// Assumes: all arguments are positive elaboration-time constants.
package lrb_pkg;

    // Greatest common divisor of two positive integers.
    function automatic int lrb_gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple, used to align the depth to both port widths.
    function automatic int lrb_lcm(input int a, input int b);
        return (a / lrb_gcd(a, b)) * b;
    endfunction

    // Round a width up to a multiple of a step.
    function automatic int lrb_round_up(input int val, input int step);
        return ((val + step - 1) / step) * step;
    endfunction

    // Width of an index that must encode values 0..count-1 (at least 1 bit).
    function automatic int lrb_idx_w(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/lrb_in_bank.sv
`timescale 1ns/1ps
// Module: lrb_in_bank
// Input bank. It collects one aligned group of N results per write and
// exposes the whole bank as a flat image for the transfer path.
// Assumes: DEPTH is a multiple of N. A write index at or beyond DEPTH/N
// matches no group and is therefore dropped.
module lrb_in_bank #(
    parameter int DW    = 32,
    parameter int N     = 2,
    parameter int DEPTH = 12,
    parameter int WI    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WI-1:0]       wr_idx,
    input  logic [N*DW-1:0]     wr_data,
    output logic [DEPTH*DW-1:0] img
);
    genvar e;
    generate
        for (e = 0; e < DEPTH; e++) begin : g_cell
            localparam int GRP  = e / N;
            localparam int LANE = e % N;
            logic [DW-1:0] cell_q;

            // Capture the matching lane when this entry's group is written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q <= '0;
                end else if (wr_en && (int'(wr_idx) == GRP)) begin
                    cell_q <= wr_data[LANE*DW +: DW];
                end
            end

            assign img[e*DW +: DW] = cell_q;
        end
    endgenerate
endmodule

// File: rtl/lrb_out_bank.sv
`timescale 1ns/1ps
// Module: lrb_out_bank
// Output bank. It holds the previous layer's vector and reloads all
// entries from the input bank image in one cycle when xfer is high.
// Assumes: the image presented at the transfer edge is the input bank
// state before any write in that same cycle (registered source).
module lrb_out_bank #(
    parameter int DW    = 32,
    parameter int DEPTH = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer,
    input  logic [DEPTH*DW-1:0] src_img,
    output logic [DEPTH*DW-1:0] img
);
    logic [DEPTH*DW-1:0] img_q;

    // Whole-bank load on transfer, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q <= '0;
        end else if (xfer) begin
            img_q <= src_img;
        end
    end

    assign img = img_q;
endmodule

// File: rtl/lrb_read_mux.sv
`timescale 1ns/1ps
// Module: lrb_read_mux
// Combinational read port. It selects an aligned group of M elements,
// optionally replaces it with the external vector, and zeroes the lanes
// at or beyond the current vector length.
// Assumes: DEPTH is a multiple of M. A group index beyond the depth
// selects no group, and its lanes are masked by the length check.
module lrb_read_mux #(
    parameter int DW    = 32,
    parameter int M     = 4,
    parameter int DEPTH = 12,
    parameter int RI    = 2,
    parameter int LW    = 4
) (
    input  logic [DEPTH*DW-1:0] bank_img,
    input  logic                ext_sel,
    input  logic [M*DW-1:0]     ext_data,
    input  logic [RI-1:0]       rd_idx,
    input  logic [LW-1:0]       rd_len,
    output logic [M*DW-1:0]     rd_data
);
    localparam int RG = DEPTH / M;

    logic [M*DW-1:0] grp_sel;

    // Pick the addressed group from the bank with constant slices.
    always_comb begin
        grp_sel = '0;
        for (int g = 0; g < RG; g++) begin
            if (int'(rd_idx) == g) begin
                grp_sel = bank_img[g*M*DW +: M*DW];
            end
        end
    end

    genvar k;
    generate
        for (k = 0; k < M; k++) begin : g_lane
            logic          in_len;
            logic [DW-1:0] src_word;

            // Lane is valid only below the vector length.
            assign in_len   = (int'(rd_idx) * M + k) < int'(rd_len);
            // Choose external or banked data for this lane.
            assign src_word = ext_sel ? ext_data[k*DW +: DW] : grp_sel[k*DW +: DW];
            assign rd_data[k*DW +: DW] = in_len ? src_word : '0;
        end
    endgenerate
endmodule

// File: rtl/lrb_top.sv
`timescale 1ns/1ps
// Module: lrb_top
// Dual-bank layer result buffer. The input bank is written N results at a
// time, the output bank is read M at a time, and a one-cycle transfer
// copies the input bank into the output bank between layers.
// Assumes: the controller pulses xfer once per layer after the last
// write, and rd_len never exceeds DEPTH.
module lrb_top
    import lrb_pkg::*;
#(
    parameter int DW        = 32,
    parameter int M         = 4,
    parameter int N         = 2,
    parameter int MAX_WIDTH = 10,
    localparam int ALIGN    = lrb_lcm(M, N),
    localparam int DEPTH    = lrb_round_up(MAX_WIDTH, ALIGN),
    localparam int WI       = lrb_idx_w(DEPTH / N),
    localparam int RI       = lrb_idx_w(DEPTH / M),
    localparam int LW       = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WI-1:0]   wr_idx,
    input  logic [N*DW-1:0] wr_data,
    input  logic            xfer,
    input  logic            ext_sel,
    input  logic [M*DW-1:0] ext_data,
    input  logic [RI-1:0]   rd_idx,
    input  logic [LW-1:0]   rd_len,
    output logic [M*DW-1:0] rd_data
);
    logic [DEPTH*DW-1:0] in_img;
    logic [DEPTH*DW-1:0] out_img;

    lrb_in_bank #(.DW(DW), .N(N), .DEPTH(DEPTH), .WI(WI)) u_in_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .img     (in_img)
    );

    lrb_out_bank #(.DW(DW), .DEPTH(DEPTH)) u_out_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer    (xfer),
        .src_img (in_img),
        .img     (out_img)
    );

    lrb_read_mux #(.DW(DW), .M(M), .DEPTH(DEPTH), .RI(RI), .LW(LW)) u_read_mux (
        .bank_img (out_img),
        .ext_sel  (ext_sel),
        .ext_data (ext_data),
        .rd_idx   (rd_idx),
        .rd_len   (rd_len),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/lrb_check.sv
`timescale 1ns/1ps
// Module: lrb_check
// Property checker for lrb_top, attached by bind. It watches both bank
// images and the read port.
// Assumes: reset is asserted for at least one edge at start-up.
module lrb_check #(
    parameter int DW    = 32,
    parameter int M     = 4,
    parameter int N     = 2,
    parameter int DEPTH = 12,
    parameter int WI    = 3,
    parameter int RI    = 2,
    parameter int LW    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [WI-1:0]       wr_idx,
    input logic                xfer,
    input logic [RI-1:0]       rd_idx,
    input logic [LW-1:0]       rd_len,
    input logic [M*DW-1:0]     rd_data,
    input logic [DEPTH*DW-1:0] in_img,
    input logic [DEPTH*DW-1:0] out_img
);
    localparam int WG = DEPTH / N;

    // R1: the first cycle out of reset sees both banks cleared.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (in_img == '0 && out_img == '0));

    // R3: no valid write means the input bank keeps every entry.
    assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || int'(wr_idx) >= WG) |=> $stable(in_img));

    // R5: a transfer copies the pre-edge input image.
    assert_xfer_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (out_img == $past(in_img)));

    // R6: the output bank holds without a transfer.
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(out_img));

    genvar k;
    generate
        for (k = 0; k < M; k++) begin : g_mask
            // R9: lanes at or past the length read as zero.
            assert_len_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
                ((int'(rd_idx) * M + k) >= int'(rd_len)) |-> (rd_data[k*DW +: DW] == '0));
        end
    endgenerate
endmodule

bind lrb_top lrb_check #(
    .DW(DW), .M(M), .N(N), .DEPTH(DEPTH), .WI(WI), .RI(RI), .LW(LW)
) u_lrb_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .xfer    (xfer),
    .rd_idx  (rd_idx),
    .rd_len  (rd_len),
    .rd_data (rd_data),
    .in_img  (in_img),
    .out_img (out_img)
);

// File: tb/lrb_top_bench.sv
`timescale 1ns/1ps
// Directed bench for lrb_top with default parameters (M=4, N=2, depth 12).
module lrb_top_bench;
    localparam int DW    = 32;
    localparam int M     = 4;
    localparam int N     = 2;
    localparam int DEPTH = 12;
    localparam int WG    = DEPTH / N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_idx = '0;
    logic [N*DW-1:0] wr_data = '0;
    logic            xfer = 1'b0;
    logic            ext_sel = 1'b0;
    logic [M*DW-1:0] ext_data = '0;
    logic [1:0]      rd_idx = '0;
    logic [3:0]      rd_len = 4'd12;
    logic [M*DW-1:0] rd_data;

    logic [DW-1:0] mdl_in  [DEPTH];
    logic [DW-1:0] mdl_out [DEPTH];
    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    lrb_top u_lrb_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .xfer(xfer), .ext_sel(ext_sel),
        .ext_data(ext_data), .rd_idx(rd_idx), .rd_len(rd_len),
        .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    // Compare the read port against the model for the current read inputs.
    task automatic check_rd(input string tag);
        for (int k = 0; k < M; k++) begin
            int elem;
            logic [DW-1:0] exp_w;
            logic [DW-1:0] got_w;
            elem = int'(rd_idx) * M + k;
            if (elem >= int'(rd_len) || elem >= DEPTH) exp_w = '0;
            else if (ext_sel) exp_w = ext_data[k*DW +: DW];
            else exp_w = mdl_out[elem];
            got_w = rd_data[k*DW +: DW];
            checks++;
            if (got_w !== exp_w) begin
                bad++;
                $display("FAIL %s grp %0d lane %0d: got %h exp %h", tag, rd_idx, k, got_w, exp_w);
            end
        end
    endtask

    task automatic read_grp(input int g, input string tag);
        @(negedge clk);
        rd_idx = 2'(g);
        #1;
        check_rd(tag);
    endtask

    task automatic read_all(input string tag);
        for (int g = 0; g < DEPTH / M; g++) read_grp(g, tag);
    endtask

    // One bus cycle: optional write and optional transfer, model updated.
    task automatic cycle(input bit we, input int g, input int base, input bit xf);
        @(negedge clk);
        wr_en  = we;
        wr_idx = 3'(g);
        for (int k = 0; k < N; k++) wr_data[k*DW +: DW] = DW'(base + k);
        xfer   = xf;
        @(negedge clk);
        wr_en = 1'b0;
        xfer  = 1'b0;
        if (xf) for (int e = 0; e < DEPTH; e++) mdl_out[e] = mdl_in[e];
        if (we && g < WG) for (int k = 0; k < N; k++) mdl_in[g*N + k] = DW'(base + k);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < DEPTH; e++) begin mdl_in[e] = '0; mdl_out[e] = '0; end
        rd_len = 4'd12;
        read_all("R1 reset");
    endtask

    task automatic t_fill_and_copy;
        for (int g = 0; g < WG; g++) cycle(1'b1, g, 32'hA000_0000 + g * 16, 1'b0);
        read_all("R4 hidden before xfer");
        cycle(1'b0, 0, 0, 1'b1);
        read_all("R5 R8 copy and lane order");
    endtask

    task automatic t_partial_update;
        cycle(1'b1, 1, 32'h0B00_0000, 1'b0);
        repeat (4) @(negedge clk);
        read_all("R6 hold without xfer");
        cycle(1'b0, 0, 0, 1'b1);
        read_all("R2 single group rewrite");
        cycle(1'b0, 0, 0, 1'b1);
        read_all("R6 input kept after xfer");
    endtask

    task automatic t_bad_index;
        cycle(1'b1, 6, 32'hDEAD_0000, 1'b0);
        cycle(1'b1, 7, 32'hBEEF_0000, 1'b0);
        cycle(1'b0, 0, 0, 1'b1);
        read_all("R3 out-of-range write");
    endtask

    task automatic t_collision;
        cycle(1'b1, 2, 32'h0C0C_0000, 1'b1);
        read_all("R7 write excluded from copy");
        cycle(1'b0, 0, 0, 1'b1);
        read_all("R7 write arrives next xfer");
    endtask

    task automatic t_length;
        rd_len = 4'd5;
        read_all("R9 len 5");
        rd_len = 4'd0;
        read_all("R9 len 0");
        rd_len = 4'd12;
        read_grp(3, "R9 group past depth");
    endtask

    task automatic t_external;
        ext_sel = 1'b1;
        for (int k = 0; k < M; k++) ext_data[k*DW +: DW] = 32'h5500_0000 + k;
        rd_len = 4'd12;
        read_all("R10 external source");
        rd_len = 4'd6;
        read_grp(1, "R10 external masked");
        ext_sel = 1'b0;
        rd_len = 4'd12;
        read_all("R10 back to bank");
    endtask

    initial begin
        t_reset();
        t_fill_and_copy();
        t_partial_update();
        t_bad_index();
        t_collision();
        t_length();
        t_external();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule